// File: doc/BRIEF.md
# Two-Digit Fault Location Display Controller

This block produces the segment drive for a two-digit seven-segment fault-location readout. In normal operation the tens digit follows a 2-bit address and the units digit follows a 4-bit address. Each digit is decoded to active-high segments. Units codes above nine blank the units digit.

Three conditions can replace the addressed code, in a fixed priority order:
- Lamp test lights every segment, so the readout shows 88.
- Self test forces the readout to 00.
- A latched secondary diagnostic error forces the readout to 22 and lights the multiplexer-card fault indicator.

Any diagnostic channel can set the error latch. Once set, it holds until an error-reset pulse or a display-reset request arrives. A saturating counter records how many clock cycles have seen a channel error. The same reset clears that counter, so the diagnostic circuits can start again from a clean state.

Top module: `fault_readout`

## Requirements
- R1: With no override, `seg_tens` shows the decoded value of `tens_addr` (0 to 3). Segment bit 0 is segment a and bit 6 is segment g, active high. The digit patterns are 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F.
- R2: With no override, `seg_units` shows the decoded value of `units_addr` for codes 0 to 9, with the encoding given in R1.
- R3: With no override, a `units_addr` value of 10 to 15 drives `seg_units` to 0x00 (blank).
- R4: While `lamp_test` is high, both digits show 0x7F. Lamp test takes priority over every other condition.
- R5: While `self_test` is high and `lamp_test` is low, both digits show 0x3F. Self test takes priority over the error display.
- R6: If any bit of `diag_err` is high on a clock edge with no reset request, the error latch is set after that edge. From then on `mux_card_led` is high and, when neither test is active, both digits show 0x5B.
- R7: Once set, the error latch stays set after `diag_err` returns to all zeros, until a reset request arrives.
- R8: A high `err_reset` on a clock edge clears the error latch and `err_count` after that edge. This reset wins over an error reported on the same edge.
- R9: A high `disp_reset` has exactly the same clearing effect as `err_reset`.
- R10: `err_count` increments by one on each clock edge where `diag_err` is nonzero and there is no reset request. It saturates at 2^CNT_W-1 (15 by default).
- R11: After `rst_n` is released, `mux_card_led` is low, `err_count` is zero, and the digits follow the addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tens_addr | input | 2 | Tens digit value |
| units_addr | input | 4 | Units digit BCD value |
| lamp_test | input | 1 | Light all segments |
| self_test | input | 1 | Force readout to 00 |
| diag_err | input | N_CH | Secondary error flag per diagnostic channel |
| err_reset | input | 1 | Error-reset pulse |
| disp_reset | input | 1 | Display-reset request |
| seg_tens | output | 7 | Tens digit segments, active high |
| seg_units | output | 7 | Units digit segments, active high |
| mux_card_led | output | 1 | Multiplexer-card fault indicator |
| err_count | output | CNT_W | Saturating count of error cycles |

## Verification
The decoding and the lamp-test and self-test overrides are combinational. The bench therefore checks them in the same cycle the inputs change, one nanosecond after each change.

The error latch and `err_count` each pass through one register. Their effects are due one clock edge after the stimulus, so the bench drives the stimulus just after an edge, advances one edge, and samples one nanosecond later. The same one-edge delay applies to the 22 display and the indicator. To confirm that stimulus applied before that edge has no visible effect yet, the bench also samples them before the edge.

// File: rtl/fault_readout.sv
module fault_readout #(
  parameter int N_CH  = 5,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       tens_addr,
  input  logic [3:0]       units_addr,
  input  logic             lamp_test,
  input  logic             self_test,
  input  logic [N_CH-1:0]  diag_err,
  input  logic             err_reset,
  input  logic             disp_reset,
  output logic [6:0]       seg_tens,
  output logic [6:0]       seg_units,
  output logic             mux_card_led,
  output logic [CNT_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [6:0] SEG_ALL  = 7'h7F;
  localparam logic [6:0] SEG_ZERO = 7'h3F;
  localparam logic [6:0] SEG_TWO  = 7'h5B;

  function automatic logic [6:0] bcd2seg(input logic [3:0] v);
    case (v)
      4'd0: bcd2seg = 7'h3F;
      4'd1: bcd2seg = 7'h06;
      4'd2: bcd2seg = 7'h5B;
      4'd3: bcd2seg = 7'h4F;
      4'd4: bcd2seg = 7'h66;
      4'd5: bcd2seg = 7'h6D;
      4'd6: bcd2seg = 7'h7D;
      4'd7: bcd2seg = 7'h07;
      4'd8: bcd2seg = 7'h7F;
      4'd9: bcd2seg = 7'h6F;
      default: bcd2seg = 7'h00;
    endcase
  endfunction

  logic err_q;
  logic [CNT_W-1:0] cnt_q;
  logic any_err, clr;

  assign any_err = |diag_err;
  assign clr     = err_reset | disp_reset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      cnt_q <= '0;
    end else if (clr) begin
      err_q <= 1'b0;
      cnt_q <= '0;
    end else if (any_err) begin
      err_q <= 1'b1;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  logic blank_in;
  assign blank_in = self_test;

  always_comb begin
    if (lamp_test) begin
      seg_tens  = SEG_ALL;
      seg_units = SEG_ALL;
    end else if (blank_in) begin
      seg_tens  = SEG_ZERO;
      seg_units = SEG_ZERO;
    end else if (err_q) begin
      seg_tens  = SEG_TWO;
      seg_units = SEG_TWO;
    end else begin
      seg_tens  = bcd2seg({2'b00, tens_addr});
      seg_units = bcd2seg(units_addr);
    end
  end

  assign mux_card_led = err_q;
  assign err_count    = cnt_q;
endmodule

module fault_readout_chk #(
  parameter int N_CH  = 5,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lamp_test,
  input logic             self_test,
  input logic [N_CH-1:0]  diag_err,
  input logic             err_reset,
  input logic             disp_reset,
  input logic [6:0]       seg_tens,
  input logic [6:0]       seg_units,
  input logic             mux_card_led,
  input logic [CNT_W-1:0] err_count
);
  a_r4_lamp_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_test |-> (seg_tens == 7'h7F && seg_units == 7'h7F));
  a_r5_self_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (self_test && !lamp_test) |-> (seg_tens == 7'h3F && seg_units == 7'h3F));
  a_r6_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((|diag_err) && !err_reset && !disp_reset) |=> mux_card_led);
  a_r6_err_shows_22: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_card_led && !lamp_test && !self_test) |-> (seg_tens == 7'h5B && seg_units == 7'h5B));
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_card_led && !err_reset && !disp_reset) |=> mux_card_led);
  a_r8_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_reset || disp_reset) |=> (!mux_card_led && err_count == '0));
  a_r10_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_reset && !disp_reset) |=> (err_count >= $past(err_count)));
endmodule

bind fault_readout fault_readout_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lamp_test(lamp_test), .self_test(self_test),
  .diag_err(diag_err), .err_reset(err_reset), .disp_reset(disp_reset),
  .seg_tens(seg_tens), .seg_units(seg_units), .mux_card_led(mux_card_led),
  .err_count(err_count)
);

// File: tb/fault_readout_tb.sv
`timescale 1ns/1ps
module fault_readout_tb;
  localparam int N_CH = 5;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] tens_addr = '0;
  logic [3:0] units_addr = '0;
  logic lamp_test = 1'b0, self_test = 1'b0;
  logic [N_CH-1:0] diag_err = '0;
  logic err_reset = 1'b0, disp_reset = 1'b0;
  logic [6:0] seg_tens, seg_units;
  logic mux_card_led;
  logic [CNT_W-1:0] err_count;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fault_readout #(.N_CH(N_CH), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tens_addr(tens_addr), .units_addr(units_addr),
    .lamp_test(lamp_test), .self_test(self_test), .diag_err(diag_err),
    .err_reset(err_reset), .disp_reset(disp_reset), .seg_tens(seg_tens),
    .seg_units(seg_units), .mux_card_led(mux_card_led), .err_count(err_count));

  function automatic logic [6:0] expseg(input int v);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    if (v > 9) return 7'h00;
    return t[v];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk_eq("R11 led", mux_card_led, 0);
    chk_eq("R11 count", err_count, 0);
    chk_eq("R11 tens", seg_tens, expseg(0));
  endtask

  task automatic t_decode();
    for (int t = 0; t < 4; t++) begin
      tens_addr = 2'(t); #1;
      chk_eq("R1 tens decode", seg_tens, expseg(t));
    end
    for (int u = 0; u < 16; u++) begin
      units_addr = 4'(u); #1;
      if (u < 10) chk_eq("R2 units decode", seg_units, expseg(u));
      else chk_eq("R3 units blank", seg_units, 0);
    end
  endtask

  task automatic t_overrides();
    tens_addr = 2'd3; units_addr = 4'd7;
    lamp_test = 1; self_test = 1; #1;
    chk_eq("R4 lamp tens", seg_tens, 7'h7F);
    chk_eq("R4 lamp units", seg_units, 7'h7F);
    lamp_test = 0; #1;
    chk_eq("R5 self tens", seg_tens, 7'h3F);
    chk_eq("R5 self units", seg_units, 7'h3F);
    self_test = 0; #1;
    chk_eq("R1 back to normal", seg_tens, expseg(3));
  endtask

  task automatic t_error();
    tens_addr = 2'd1; units_addr = 4'd4;
    diag_err = 5'b00100; #1;
    chk_eq("R6 not before edge", mux_card_led, 0);
    chk_eq("R6 display before edge", seg_units, expseg(4));
    step();
    chk_eq("R6 led", mux_card_led, 1);
    chk_eq("R6 tens 2", seg_tens, 7'h5B);
    chk_eq("R6 units 2", seg_units, 7'h5B);
    chk_eq("R10 count 1", err_count, 1);
    diag_err = '0;
    step(); step();
    chk_eq("R7 sticky", mux_card_led, 1);
    chk_eq("R10 holds", err_count, 1);
    self_test = 1; #1;
    chk_eq("R5 self over error", seg_units, 7'h3F);
    lamp_test = 1; #1;
    chk_eq("R4 lamp over all", seg_tens, 7'h7F);
    lamp_test = 0; self_test = 0;
    err_reset = 1; diag_err = 5'b10000;
    step();
    err_reset = 0; diag_err = '0;
    chk_eq("R8 clear led", mux_card_led, 0);
    chk_eq("R8 clear count", err_count, 0);
    chk_eq("R8 display normal", seg_units, expseg(4));
  endtask

  task automatic t_disp_reset_and_sat();
    diag_err = 5'b00001;
    for (int i = 0; i < 20; i++) step();
    chk_eq("R10 saturate", err_count, 15);
    diag_err = 5'b01000;
    step();
    chk_eq("R10 stays max", err_count, 15);
    diag_err = '0;
    disp_reset = 1; #1;
    chk_eq("R9 not before edge", mux_card_led, 1);
    step();
    disp_reset = 0;
    chk_eq("R9 clear led", mux_card_led, 0);
    chk_eq("R9 clear count", err_count, 0);
    diag_err = 5'b00011; step(); step(); diag_err = '0;
    chk_eq("R10 two cycles", err_count, 2);
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #22 rst_n = 1;
    step();
    t_reset();
    t_decode();
    t_overrides();
    t_error();
    t_disp_reset_and_sat();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule